// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a data word by a number of clock cycles chosen at run time, anywhere from zero to sixty-three. The chain is built from six shift sections whose lengths are powers of two. Each bit of a six-bit delay code either routes the stream through its section or steers the stream around it. The total delay is therefore the sum of the lengths of the enabled sections.

The sections run from the longest, next to the input, to the shortest, next to the output. Every register shifts on every clock edge, whether or not its section is in the path. A code of zero gives a purely combinational path from input to output. Changing the code while data flows is allowed. The output is only guaranteed to be correct once the new delay's worth of cycles has passed.

Top module: `bwdelay_line`

## Requirements
- R1: With the delay code held at value D, the output in any cycle equals the input word presented D cycles earlier. D is the unsigned value of the code.
- R2: A delay code of zero connects the input to the output combinationally, in the same cycle.
- R3: Code bit k enables a section of 2^k stages. From input to output, the sections are ordered bit 5 (32 stages) first and bit 0 (1 stage) last. A code with only bit k set gives a delay of exactly 2^k cycles.
- R4: Reset is synchronous and active low, and it clears every stage to zero. After reset is released with a nonzero code D, the output reads zero for the first D cycles.
- R5: A section that is bypassed keeps shifting its input. When the code moves from zero to 32, the output in the very first cycle equals the input from 32 cycles earlier.
- R6: When the code changes to a new value B, the output matches the input from B cycles earlier in every cycle from B cycles after the change onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears all stages |
| delay_code | input | CODE_W (6) | Unsigned delay in cycles; bit k enables the 2^k-stage section |
| din | input | DATA_W (8) | Data word entering the chain |
| dout | output | DATA_W (8) | Delayed data word |

## Verification
A corrupted stage shows up at dout only while its section lies in the selected path. It appears after the number of cycles that separates that stage from the output through the enabled sections downstream. A short code therefore exposes faults in the first sections only late or not at all.

For that reason the bench sweeps every single-bit code and several mixed codes. Each pattern is a stream of distinct values whose period is longer than the maximum delay, so a wrong stage count, a swapped section or a miswired select bit shows up as the wrong word within one delay period. Retuning and bypassed-shift runs reveal any section that stops shifting when it is not selected.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    // Number of stages in the section controlled by code bit k.
    function automatic int unsigned sect_len(input int unsigned bit_idx);
        return 32'd1 << bit_idx;
    endfunction
endpackage

// File: rtl/tdl_section.sv
module tdl_section #(
    parameter int DATA_W = 8,
    parameter int LEN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sect_in,
    output logic [DATA_W-1:0] sect_out
);
    typedef struct packed {
        logic [LEN-1:0][DATA_W-1:0] stage;
    } sect_t;

    sect_t sect_d, sect_q;

    always_comb begin
        sect_d          = sect_q;
        sect_d.stage[0] = sect_in;
        for (int i = 1; i < LEN; i++) begin
            sect_d.stage[i] = sect_q.stage[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q <= '0;
        end else begin
            sect_q <= sect_d;
        end
    end

    assign sect_out = sect_q.stage[LEN-1];

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R5
    head_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(rst_n)) |-> sect_q.stage[0] == $past(sect_in));
endmodule

// File: rtl/tdl_bypass_mux.sv
module tdl_bypass_mux #(
    parameter int DATA_W = 8
) (
    input  logic              use_sect,
    input  logic [DATA_W-1:0] direct,
    input  logic [DATA_W-1:0] delayed,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        y = use_sect ? delayed : direct;
    end
endmodule

// File: rtl/bwdelay_line.sv
module bwdelay_line #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] delay_code,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // tap[CODE_W] is the input; tap[k] leaves the stage set for bit k.
    logic [CODE_W:0][DATA_W-1:0] tap;

    assign tap[CODE_W] = din;

    for (genvar k = CODE_W - 1; k >= 0; k--) begin : g_sect
        logic [DATA_W-1:0] sect_out;

        tdl_section #(
            .DATA_W(DATA_W),
            .LEN   (int'(tdl_pkg::sect_len(k)))
        ) u_sect (
            .clk     (clk),
            .rst_n   (rst_n),
            .sect_in (tap[k+1]),
            .sect_out(sect_out)
        );

        tdl_bypass_mux #(
            .DATA_W(DATA_W)
        ) u_mux (
            .use_sect(delay_code[k]),
            .direct  (tap[k+1]),
            .delayed (sect_out),
            .y       (tap[k])
        );
    end

    assign dout = tap[0];

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R2
    zero_code_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_code == '0) |-> dout == din);

    // R4
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(!rst_n) && delay_code[0]) |-> dout == '0);

    // R1
    unit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(rst_n) && delay_code == CODE_W'(1) && $past(delay_code) == CODE_W'(1))
        |-> dout == $past(din));
endmodule

// File: tb/bwdelay_line_tb_top.sv
module bwdelay_line_tb_top;
    localparam int DW = 8;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] delay_code = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    always #2 clk = ~clk;

    bwdelay_line #(.DATA_W(DW), .CODE_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .delay_code(delay_code), .din(din), .dout(dout)
    );

    int total = 0;
    int bad = 0;
    int cyc = 64;
    int valid_from = 0;
    int cur_code = 0;
    bit cur_rst = 1'b0;
    string req = "R4";
    logic [DW-1:0] hist [0:8191];

    initial begin
        for (int i = 0; i < 8192; i++) hist[i] = '0;
    end

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d code=%0d dout=%0h expected=%0h", req, cyc, cur_code, act, exp);
        end
    endtask

    // One cycle: drive after the edge, sample mid-cycle.
    task automatic step(input bit chk);
        logic [DW-1:0] val;
        @(posedge clk);
        cyc++;
        #1;
        val        = DW'(cyc * 29 + 3);
        rst_n      = cur_rst;
        delay_code = CW'(cur_code);
        din        = cur_rst ? val : 8'hFF;
        hist[cyc]  = cur_rst ? val : '0;
        #1;
        if (chk && cyc >= valid_from) check(dout, hist[cyc - cur_code]);
    endtask

    task automatic set_code(input int c);
        cur_code   = c;
        valid_from = cyc + 1 + c;
    endtask

    task automatic t_reset();
        req = "R4";
        cur_rst = 1'b0;
        cur_code = 63;
        for (int i = 0; i < 3; i++) step(1'b0);
        cur_rst = 1'b1;
        valid_from = cyc + 1;
        for (int i = 0; i < 63; i++) begin
            step(1'b0);
            check(dout, '0);
        end
        req = "R1";
        for (int i = 0; i < 10; i++) step(1'b1);
    endtask

    task automatic t_zero();
        req = "R2";
        set_code(0);
        for (int i = 0; i < 20; i++) step(1'b1);
    endtask

    task automatic t_single_bits();
        req = "R3";
        for (int k = 0; k < CW; k++) begin
            set_code(1 << k);
            for (int i = 0; i < (1 << k) + 8; i++) step(1'b1);
        end
    endtask

    task automatic t_mixed();
        int codes [5] = '{33, 21, 42, 63, 7};
        req = "R1";
        foreach (codes[j]) begin
            set_code(codes[j]);
            for (int i = 0; i < codes[j] + 8; i++) step(1'b1);
        end
    endtask

    task automatic t_bypassed_shift();
        req = "R5";
        set_code(0);
        for (int i = 0; i < 40; i++) step(1'b1);
        cur_code = 32;
        valid_from = cyc + 1;
        for (int i = 0; i < 12; i++) step(1'b1);
        set_code(0);
        for (int i = 0; i < 4; i++) step(1'b1);
        cur_code = 1;
        valid_from = cyc + 1;
        for (int i = 0; i < 6; i++) step(1'b1);
    endtask

    task automatic t_retune();
        req = "R6";
        set_code(63);
        for (int i = 0; i < 70; i++) step(1'b1);
        set_code(5);
        for (int i = 0; i < 20; i++) step(1'b1);
        set_code(48);
        for (int i = 0; i < 60; i++) step(1'b1);
        set_code(3);
        for (int i = 0; i < 10; i++) step(1'b1);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_single_bits();
        t_mixed();
        t_bypassed_shift();
        t_retune();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog cyc=%0d dout=%0h expected=finish", cyc, dout);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule